// File: doc/BRIEF.md
# Lithium-Ion Cell Protection Controller

This block watches the digitized outputs of a lithium-ion cell's fault comparators and drives the two active-low FET control outputs. One output gates the charge path and the other gates the discharge path. Each fault has to be seen on its input for its own qualification delay before it acts. Each fault turns off only the paths that it endangers. Each fault stays in force until its own release comparison is seen. Release is judged from the pack-terminal comparisons, not by a timer.

The block keeps sticky fault flags and two host enable bits. It presents them, together with mirrors of the two control outputs, as one 8-bit protection register. The host writes that register to clear flags and to set the enables. An undervoltage fault also raises a sleep request to the power manager. The power manager's sleep state comes back in on a plain input. When the block leaves sleep, both enables are set again. All ports are plain control and status levels. No data stream passes through the block, so it has no valid/ready handshake and no back-pressure.

Top module: `cell_guard`

## Requirements
- R1: Overvoltage. When `cell_over_ov` has been sampled high on OV_DLY consecutive rising edges, the OV flag (register bit 7) is set and `chg_off` goes high on that edge. `dis_off` is not affected. One edge with `cell_under_ce` high and `cell_over_ov` low releases the fault. The flag stays set after the release.
- R2: Undervoltage. When `cell_under_uv` has been sampled high on UV_DLY consecutive edges, the UV flag (bit 6) is set, both outputs go high and `sleep_req` goes high. One edge with `pack_above_vdd` high releases the fault and drops `sleep_req`.
- R3: Charge overcurrent. When `chg_oc` has been high for OC_DLY edges, the COC flag (bit 5) is set and both outputs go high. Only `pack_below_rel` releases this fault. `pack_above_rel` has no effect on it.
- R4: Discharge overcurrent (`dis_oc` for OC_DLY edges) and short circuit (`short_det` for SC_DLY edges) each set the DOC flag (bit 4) and raise only `dis_off`. Only `pack_above_rel` releases them. `pack_below_rel` has no effect.
- R5: `chg_off` is high while any of these holds: an overvoltage, undervoltage or charge-overcurrent fault, CE=0, or `sleep_in`=1. `dis_off` is high while any of these holds: an undervoltage, charge-overcurrent, discharge-overcurrent or short-circuit fault, DE=0, or `sleep_in`=1.
- R6: `prot_reg` holds, from bit 7 down to bit 0: OV, UV, COC, DOC, a mirror of `chg_off`, a mirror of `dis_off`, CE, DE. After reset with `sleep_in` low it reads 8'h03.
- R7: The four flags stay set until the host clears them. On the first edge that sees `sleep_in` low after it was high, CE and DE are both set to 1. This takes priority over a host write on the same edge.
- R8: A qualification count starts again from zero whenever its input is sampled low before the delay has been reached.
- R9: A host write (`host_wr_en` high at an edge) clears each flag whose bit in `host_wr_data` is 0. Writing 1 to a flag bit leaves the flag as it is. The write loads CE and DE from bits 1 and 0. Bits 3 and 2 of the write are ignored. A flag that qualifies on the same edge as a clear stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cell_over_ov | input | 1 | Cell voltage above the overvoltage threshold |
| cell_under_ce | input | 1 | Cell voltage below the charge-enable release level |
| cell_under_uv | input | 1 | Cell voltage below the undervoltage threshold |
| chg_oc | input | 1 | Charge-direction overcurrent comparator |
| dis_oc | input | 1 | Discharge-direction overcurrent comparator |
| short_det | input | 1 | Short-circuit comparator |
| pack_above_vdd | input | 1 | Pack terminal above supply (charger present) |
| pack_below_rel | input | 1 | Pack terminal below supply minus the test margin |
| pack_above_rel | input | 1 | Pack terminal above supply minus the test margin |
| sleep_in | input | 1 | Power manager reports sleep |
| host_wr_en | input | 1 | Host write strobe for the protection register |
| host_wr_data | input | 8 | Host write data |
| prot_reg | output | 8 | Protection register readback |
| chg_off | output | 1 | Charge FET control, high turns the FET off |
| dis_off | output | 1 | Discharge FET control, high turns the FET off |
| sleep_req | output | 1 | Sleep request from undervoltage |

## Verification
Suppose a fault input is raised just after a falling edge. Its effect is due on the rising edge that samples it for the N-th time, where N is the fault's delay. The bench therefore samples it first at the falling edge after N−1 rising edges, expecting no effect, and again one cycle later, expecting the effect. Releases and host writes act on the first rising edge after they are driven. Leaving sleep restores the enables on the first edge that sees `sleep_in` low. Each of these is checked at the falling edge that follows. The outputs are combinational from the registered state and from `sleep_in`, so a change on `sleep_in` is checked half a cycle after it is driven.

// File: rtl/cell_guard_pkg.sv
package cell_guard_pkg;
  localparam int NUM_COND = 5;
  localparam int NUM_FAULT = 4;

  // qualifier index for each comparator input
  localparam int Q_OV  = 0;
  localparam int Q_UV  = 1;
  localparam int Q_COC = 2;
  localparam int Q_DOC = 3;
  localparam int Q_SC  = 4;

  typedef struct packed {
    logic ov;
    logic uv;
    logic coc;
    logic doc;
  } fault_vec_t;
endpackage

// File: rtl/guard_qualify.sv
module guard_qualify #(
  parameter int unsigned DELAY = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cond,
  output logic hit
);
  localparam int CW = (DELAY < 2) ? 1 : $clog2(DELAY);
  localparam logic [CW-1:0] LIMIT = CW'(DELAY - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)            cnt <= '0;
    else if (!cond)        cnt <= '0;
    else if (cnt != LIMIT) cnt <= cnt + 1'b1;
  end

  assign hit = cond && (cnt == LIMIT);

  // R8: with a delay above one, qualification needs the condition on the previous edge too
  assert_hit_needs_history_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ((LIMIT != '0) && hit) |-> $past(cond));
endmodule

// File: rtl/guard_faults.sv
module guard_faults
  import cell_guard_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_FAULT-1:0] set_vec,  // {ov, uv, coc, doc}
  input  logic [NUM_FAULT-1:0] rel_vec,
  output fault_vec_t           active
);
  logic [NUM_FAULT-1:0] st;

  for (genvar g = 0; g < NUM_FAULT; g++) begin : g_fault
    always_ff @(posedge clk) begin
      if (!rst_n)          st[g] <= 1'b0;
      else if (set_vec[g]) st[g] <= 1'b1;
      else if (rel_vec[g]) st[g] <= 1'b0;
    end
  end

  assign active = fault_vec_t'(st);
endmodule

// File: rtl/guard_regs.sv
module guard_regs
  import cell_guard_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_FAULT-1:0] flag_set,
  input  logic                 wr_en,
  input  logic [NUM_FAULT-1:0] wr_flags,
  input  logic [1:0]           wr_enables,  // {ce, de}
  input  logic                 sleep_in,
  output logic [NUM_FAULT-1:0] flags,
  output logic                 ce,
  output logic                 de
);
  logic sleep_q;
  logic wake;

  assign wake = sleep_q && !sleep_in;

  always_ff @(posedge clk) begin
    if (!rst_n) sleep_q <= 1'b1;
    else        sleep_q <= sleep_in;
  end

  for (genvar g = 0; g < NUM_FAULT; g++) begin : g_flag
    always_ff @(posedge clk) begin
      if (!rst_n)           flags[g] <= 1'b0;
      else if (flag_set[g]) flags[g] <= 1'b1;
      else if (wr_en)       flags[g] <= flags[g] & wr_flags[g];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ce <= 1'b1;
      de <= 1'b1;
    end else if (wake) begin
      ce <= 1'b1;
      de <= 1'b1;
    end else if (wr_en) begin
      ce <= wr_enables[1];
      de <= wr_enables[0];
    end
  end
endmodule

// File: rtl/cell_guard.sv
module cell_guard
  import cell_guard_pkg::*;
#(
  parameter int unsigned OV_DLY = 8,
  parameter int unsigned UV_DLY = 12,
  parameter int unsigned OC_DLY = 6,
  parameter int unsigned SC_DLY = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cell_over_ov,
  input  logic       cell_under_ce,
  input  logic       cell_under_uv,
  input  logic       chg_oc,
  input  logic       dis_oc,
  input  logic       short_det,
  input  logic       pack_above_vdd,
  input  logic       pack_below_rel,
  input  logic       pack_above_rel,
  input  logic       sleep_in,
  input  logic       host_wr_en,
  input  logic [7:0] host_wr_data,
  output logic [7:0] prot_reg,
  output logic       chg_off,
  output logic       dis_off,
  output logic       sleep_req
);
  localparam int unsigned DLY [NUM_COND] = '{OV_DLY, UV_DLY, OC_DLY, OC_DLY, SC_DLY};

  logic [NUM_COND-1:0]  cond;
  logic [NUM_COND-1:0]  hit;
  logic [NUM_FAULT-1:0] set_vec;
  logic [NUM_FAULT-1:0] rel_vec;
  logic [NUM_FAULT-1:0] flags;
  fault_vec_t           act;
  logic                 ce;
  logic                 de;

  assign cond[Q_OV]  = cell_over_ov;
  assign cond[Q_UV]  = cell_under_uv;
  assign cond[Q_COC] = chg_oc;
  assign cond[Q_DOC] = dis_oc;
  assign cond[Q_SC]  = short_det;

  for (genvar g = 0; g < NUM_COND; g++) begin : g_qual
    guard_qualify #(.DELAY(DLY[g])) i_qual (
      .clk  (clk),
      .rst_n(rst_n),
      .cond (cond[g]),
      .hit  (hit[g])
    );
  end

  // fault order {ov, uv, coc, doc}; short circuit shares the discharge fault
  assign set_vec = {hit[Q_OV], hit[Q_UV], hit[Q_COC], hit[Q_DOC] | hit[Q_SC]};
  assign rel_vec = {cell_under_ce, pack_above_vdd, pack_below_rel, pack_above_rel};

  guard_faults i_faults (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_vec(set_vec),
    .rel_vec(rel_vec),
    .active (act)
  );

  guard_regs i_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .flag_set  (set_vec),
    .wr_en     (host_wr_en),
    .wr_flags  (host_wr_data[7:4]),
    .wr_enables(host_wr_data[1:0]),
    .sleep_in  (sleep_in),
    .flags     (flags),
    .ce        (ce),
    .de        (de)
  );

  assign chg_off   = act.ov | act.uv | act.coc | !ce | sleep_in;
  assign dis_off   = act.uv | act.coc | act.doc | !de | sleep_in;
  assign sleep_req = act.uv;
  assign prot_reg  = {flags, chg_off, dis_off, ce, de};

  assert_ov_after_input_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(act.ov) |-> $past(cell_over_ov));

  assert_ov_release_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (cell_under_ce && !cell_over_ov) |=> !act.ov);

  assert_sleep_req_source_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sleep_req) |-> $past(cell_under_uv));

  assert_flag_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (prot_reg[7] && !(host_wr_en && !host_wr_data[7])) |=> prot_reg[7]);

  assert_wake_enables_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sleep_in) |=> (prot_reg[1:0] == 2'b11));
endmodule

// File: tb/test_cell_guard.sv
module test_cell_guard;
  localparam int OV_DLY = 8;
  localparam int UV_DLY = 12;
  localparam int OC_DLY = 6;
  localparam int SC_DLY = 2;

  logic clk = 1'b0;
  logic rst_n;
  logic cell_over_ov, cell_under_ce, cell_under_uv, chg_oc, dis_oc, short_det;
  logic pack_above_vdd, pack_below_rel, pack_above_rel, sleep_in, host_wr_en;
  logic [7:0] host_wr_data;
  logic [7:0] prot_reg;
  logic chg_off, dis_off, sleep_req;
  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  cell_guard #(.OV_DLY(OV_DLY), .UV_DLY(UV_DLY), .OC_DLY(OC_DLY), .SC_DLY(SC_DLY)) i_cell_guard (
    .clk(clk), .rst_n(rst_n), .cell_over_ov(cell_over_ov), .cell_under_ce(cell_under_ce),
    .cell_under_uv(cell_under_uv), .chg_oc(chg_oc), .dis_oc(dis_oc), .short_det(short_det),
    .pack_above_vdd(pack_above_vdd), .pack_below_rel(pack_below_rel),
    .pack_above_rel(pack_above_rel), .sleep_in(sleep_in), .host_wr_en(host_wr_en),
    .host_wr_data(host_wr_data), .prot_reg(prot_reg), .chg_off(chg_off),
    .dis_off(dis_off), .sleep_req(sleep_req));

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic host_write(input logic [7:0] d);
    host_wr_en = 1'b1;
    host_wr_data = d;
    cyc(1);
    host_wr_en = 1'b0;
  endtask

  task automatic pulse_rel(ref logic sig);
    sig = 1'b1;
    cyc(1);
    sig = 1'b0;
  endtask

  task automatic t_reset;
    chk("R6 reset value", prot_reg, 8'h03);
    chk("R2 reset sleep_req", {7'd0, sleep_req}, 8'h00);
  endtask

  task automatic t_overvoltage;
    cell_over_ov = 1'b1;
    cyc(OV_DLY - 1);
    chk("R1 ov before delay", prot_reg, 8'h03);
    cyc(1);
    chk("R1 ov qualified", prot_reg, 8'h8B);
    chk("R1 discharge kept on", {7'd0, dis_off}, 8'h00);
    cell_over_ov = 1'b0;
    pulse_rel(cell_under_ce);
    chk("R7 ov released flag sticky", prot_reg, 8'h83);
    host_write(8'h73);
    chk("R9 ov flag cleared", prot_reg, 8'h03);
  endtask

  task automatic t_restart;
    cell_over_ov = 1'b1;
    cyc(OV_DLY - 1);
    cell_over_ov = 1'b0;
    cyc(1);
    cell_over_ov = 1'b1;
    cyc(OV_DLY - 1);
    chk("R8 count restarted", prot_reg, 8'h03);
    cyc(1);
    chk("R8 full run qualifies", prot_reg, 8'h8B);
    cell_over_ov = 1'b0;
    pulse_rel(cell_under_ce);
    host_write(8'h03);
  endtask

  task automatic t_undervoltage;
    cell_under_uv = 1'b1;
    cyc(UV_DLY - 1);
    chk("R2 uv before delay", {prot_reg[7:1], sleep_req}, 8'h02);
    cyc(1);
    chk("R2 uv qualified", prot_reg, 8'h4F);
    chk("R2 sleep request", {7'd0, sleep_req}, 8'h01);
    cell_under_uv = 1'b0;
    sleep_in = 1'b1;
    cyc(1);
    host_write(8'h40);
    chk("R5 asleep with enables low", prot_reg, 8'h4C);
    pulse_rel(pack_above_vdd);
    chk("R2 charger release", {7'd0, sleep_req}, 8'h00);
    chk("R5 sleep keeps outputs off", prot_reg, 8'h4C);
    sleep_in = 1'b0;
    cyc(1);
    chk("R7 wake restores enables", prot_reg, 8'h43);
    host_write(8'h03);
    chk("R9 uv flag cleared", prot_reg, 8'h03);
  endtask

  task automatic t_charge_oc;
    chg_oc = 1'b1;
    cyc(OC_DLY - 1);
    chk("R3 coc before delay", prot_reg, 8'h03);
    cyc(1);
    chk("R3 coc qualified", prot_reg, 8'h2F);
    chg_oc = 1'b0;
    pack_above_rel = 1'b1;
    cyc(2);
    pack_above_rel = 1'b0;
    chk("R3 wrong release ignored", prot_reg, 8'h2F);
    pulse_rel(pack_below_rel);
    chk("R3 coc released", prot_reg, 8'h23);
    host_write(8'h03);
  endtask

  task automatic t_discharge_oc;
    dis_oc = 1'b1;
    cyc(OC_DLY - 1);
    chk("R4 doc before delay", prot_reg, 8'h03);
    cyc(1);
    chk("R4 doc qualified", prot_reg, 8'h17);
    dis_oc = 1'b0;
    pack_below_rel = 1'b1;
    cyc(2);
    pack_below_rel = 1'b0;
    chk("R4 wrong release ignored", prot_reg, 8'h17);
    pulse_rel(pack_above_rel);
    chk("R4 doc released", prot_reg, 8'h13);
    host_write(8'h03);
  endtask

  task automatic t_short;
    short_det = 1'b1;
    cyc(SC_DLY - 1);
    chk("R4 short before delay", prot_reg, 8'h03);
    cyc(1);
    chk("R4 short qualified", prot_reg, 8'h17);
    short_det = 1'b0;
    pulse_rel(pack_above_rel);
    chk("R4 short released", prot_reg, 8'h13);
    host_write(8'h03);
  endtask

  task automatic t_host;
    host_write(8'h01);
    chk("R5 ce low turns charge off", prot_reg, 8'h09);
    host_write(8'h02);
    chk("R5 de low turns discharge off", prot_reg, 8'h06);
    host_write(8'h0F);
    chk("R9 mirror writes ignored", prot_reg, 8'h03);
    host_write(8'hF3);
    chk("R9 writing one sets no flag", prot_reg, 8'h03);
    sleep_in = 1'b1;
    #1;
    chk("R5 sleep forces both off", {6'd0, chg_off, dis_off}, 8'h03);
    cyc(1);
    sleep_in = 1'b0;
    cyc(1);
    chk("R5 awake outputs on", prot_reg, 8'h03);
  endtask

  initial begin
    rst_n = 1'b0;
    {cell_over_ov, cell_under_ce, cell_under_uv, chg_oc, dis_oc, short_det} = '0;
    {pack_above_vdd, pack_below_rel, pack_above_rel, sleep_in, host_wr_en} = '0;
    host_wr_data = 8'h00;
    cyc(3);
    rst_n = 1'b1;
    cyc(1);
    t_reset();
    t_overvoltage();
    t_restart();
    t_undervoltage();
    t_charge_oc();
    t_discharge_oc();
    t_short();
    t_host();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #1_000_000;
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule